// File: doc/BRIEF.md
# Burst SRAM Access and Address Controller

This block is the clocked control front end of a word-wide burst SRAM. Every cycle it looks at two address strobes (one meant for a processor, one for a cache or memory controller), three chip enables, an advance input and the write controls. From these it decides whether the cycle starts a new access, continues or holds a running burst, or deselects the part. It then issues one read or write command per cycle, with a per-byte write mask, to the behavioural memory array inside the block.

When an access starts, the block registers the upper address bits and loads the low two bits into a wraparound burst counter. A static order input picks the burst order. Linear order counts the low bits up modulo 4. Interleaved order XORs the start value with the step number. The two strobes differ in priority and in write latency. A processor-strobe access always opens as a read, so its write lands on the following clock. A controller-strobe access writes in the cycle it is issued. Read data comes out of a registered array port one clock after the read command.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The part counts as selected only when `sel0_n` is 0, `sel1` is 1 and `sel2_n` is 0. A strobe cycle taken while unselected issues no command and ends any running burst.
- R2: When both strobes are low and `sel0_n` is 0, only the processor strobe is honoured. When `sel0_n` is 1, `astb_cpu_n` is ignored.
- R3: A processor-strobe cycle always issues a read at `addr_in`, whatever the write inputs and `step_n` are. A write can follow on the next clock as a hold or continue cycle.
- R4: A controller-strobe cycle on a selected part issues its command at `addr_in` in the same cycle, writing if the write inputs are active. `step_n` is ignored in that cycle.
- R5: `wr_all_n` = 0 makes a write with `cmd_mask` = 4'b1111, whatever `wr_byte_n` and `lane_n` are.
- R6: With `wr_all_n` = 1 and `wr_byte_n` = 0, the cycle writes with `cmd_mask` = ~`lane_n`, where bit i stands for data bits [8i+7:8i]. With `wr_byte_n` = 1, or with all of `lane_n` high, the cycle is a read.
- R7: Bytes whose mask bit is 0 keep their previous contents in the array.
- R8: A cycle with no honoured strobe and `step_n` = 0 moves a running burst to its next address. With `step_n` = 1 it keeps the current address.
- R9: With `lin_order` = 1, burst step k uses low bits (start + k) mod 4, while the upper address bits stay fixed.
- R10: With `lin_order` = 0, burst step k uses low bits start XOR k.
- R11: Hold and continue cycles issue no command while no burst is running, that is, after reset or after a deselect.
- R12: A read command returns the array word on `rdata`, with `rvalid` = 1, one clock after the command edge.
- R13: While `rst` is high, and in the first cycle after it, `cmd_valid` and `rvalid` are 0 when no strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| astb_cpu_n | input | 1 | Processor address strobe, active low |
| astb_ctl_n | input | 1 | Controller address strobe, active low |
| sel0_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_n | input | NBYTES | Byte selects, active low |
| lin_order | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr_in | input | AW | Word address |
| wdata | input | NBYTES*BYTE_W | Write data |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_write | output | 1 | Issued command is a write |
| cmd_addr | output | AW | Address of the issued command |
| cmd_mask | output | NBYTES | Byte mask of a write, 0 for reads |
| rdata | output | NBYTES*BYTE_W | Registered read data |
| rvalid | output | 1 | rdata holds the result of the previous cycle's read |

## Verification
The command outputs are combinational from the inputs of the current cycle and the burst state. The bench therefore drives each cycle's inputs just after a falling edge and checks `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_mask` one nanosecond later, before the rising edge that acts on them. Read data is due one rising edge after the read command, so it is checked at the next falling edge, before the next cycle's inputs are applied. Writes, including masked ones, are confirmed through a later read that is compared against a word image the bench builds from the masks alone. Both burst orders are swept over all four start values with three advances and a hold.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DESEL,
        ACC_START_CPU,
        ACC_START_CTL,
        ACC_CONT,
        ACC_HOLD
    } acc_e;

    typedef struct packed {
        acc_e kind;
        logic issue;
        logic write;
    } dec_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] k,
                                            input logic       lin);
        logic [1:0] r;
        if (lin)
            r = start + k;
        else
            r = start ^ k;
        return r;
    endfunction

endpackage

// File: rtl/sbc_access_decode.sv
module sbc_access_decode
    import sbc_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              rst,
    input  logic              astb_cpu_n,
    input  logic              astb_ctl_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [NBYTES-1:0] lane_n,
    input  logic              active,
    output dec_t              dec,
    output logic [NBYTES-1:0] mask
);
    logic              selected;
    logic              cpu_take;
    logic              any_strobe;
    logic [NBYTES-1:0] req_mask;
    logic              may_write;

    always_comb begin
        selected   = !sel0_n && sel1 && !sel2_n;
        cpu_take   = !astb_cpu_n && !sel0_n;
        any_strobe = cpu_take || !astb_ctl_n;

        if (!wr_all_n)
            req_mask = '1;
        else if (!wr_byte_n)
            req_mask = ~lane_n;
        else
            req_mask = '0;

        dec.kind = ACC_NONE;
        if (rst)
            dec.kind = ACC_NONE;
        else if (any_strobe)
            dec.kind = !selected ? ACC_DESEL
                     : (cpu_take ? ACC_START_CPU : ACC_START_CTL);
        else if (active)
            dec.kind = step_n ? ACC_HOLD : ACC_CONT;

        dec.issue = (dec.kind == ACC_START_CPU) || (dec.kind == ACC_START_CTL) ||
                    (dec.kind == ACC_CONT) || (dec.kind == ACC_HOLD);
        may_write = (dec.kind == ACC_START_CTL) || (dec.kind == ACC_CONT) ||
                    (dec.kind == ACC_HOLD);
        dec.write = may_write && (req_mask != '0);
        mask      = dec.write ? req_mask : '0;
    end
endmodule

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq
    import sbc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_e          kind,
    input  logic          lin_order,
    input  logic [AW-1:0] addr_in,
    output logic          active,
    output logic [AW-1:0] cmd_addr
);
    localparam int HI_W = AW - 2;

    logic [HI_W-1:0] base_hi;
    logic [1:0]      start_lo;
    logic [1:0]      step;
    logic [1:0]      cur_lo;
    logic [1:0]      nxt_lo;

    always_comb begin
        cur_lo = burst_lo(start_lo, step, lin_order);
        nxt_lo = burst_lo(start_lo, step + 2'd1, lin_order);
        case (kind)
            ACC_START_CPU, ACC_START_CTL: cmd_addr = addr_in;
            ACC_CONT:                     cmd_addr = {base_hi, nxt_lo};
            default:                      cmd_addr = {base_hi, cur_lo};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            base_hi  <= '0;
            start_lo <= '0;
            step     <= '0;
        end else begin
            case (kind)
                ACC_START_CPU, ACC_START_CTL: begin
                    active   <= 1'b1;
                    base_hi  <= addr_in[AW-1:2];
                    start_lo <= addr_in[1:0];
                    step     <= '0;
                end
                ACC_DESEL: active <= 1'b0;
                ACC_CONT:  step   <= step + 2'd1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sbc_mem_array.sv
module sbc_mem_array #(
    parameter int AW     = 10,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue,
    input  logic                     write,
    input  logic [AW-1:0]            addr,
    input  logic [NBYTES-1:0]        mask,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rvalid
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NBYTES * BYTE_W;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (issue && write) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (mask[b])
                    store[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
        if (issue && !write)
            rdata <= store[addr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= issue && !write;
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import sbc_pkg::*;
#(
    parameter int AW     = 10,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     astb_cpu_n,
    input  logic                     astb_ctl_n,
    input  logic                     sel0_n,
    input  logic                     sel1,
    input  logic                     sel2_n,
    input  logic                     step_n,
    input  logic                     wr_all_n,
    input  logic                     wr_byte_n,
    input  logic [NBYTES-1:0]        lane_n,
    input  logic                     lin_order,
    input  logic [AW-1:0]            addr_in,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic                     cmd_valid,
    output logic                     cmd_write,
    output logic [AW-1:0]            cmd_addr,
    output logic [NBYTES-1:0]        cmd_mask,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rvalid
);
    dec_t dec;
    logic active;

    sbc_access_decode #(.NBYTES(NBYTES)) dec_u (
        .rst(rst), .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .active(active), .dec(dec), .mask(cmd_mask)
    );

    sbc_burst_seq #(.AW(AW)) seq_u (
        .clk(clk), .rst(rst), .kind(dec.kind), .lin_order(lin_order),
        .addr_in(addr_in), .active(active), .cmd_addr(cmd_addr)
    );

    sbc_mem_array #(.AW(AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) mem_u (
        .clk(clk), .rst(rst), .issue(dec.issue), .write(dec.write),
        .addr(cmd_addr), .mask(cmd_mask), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    assign cmd_valid = dec.issue;
    assign cmd_write = dec.write;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int AW     = 10,
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              astb_cpu_n,
    input logic              astb_ctl_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              step_n,
    input logic              wr_all_n,
    input logic [AW-1:0]     addr_in,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic [AW-1:0]     cmd_addr,
    input logic [NBYTES-1:0] cmd_mask,
    input logic              rvalid
);
    logic sel_ok;
    logic strobe_seen;
    assign sel_ok      = !sel0_n && sel1 && !sel2_n;
    assign strobe_seen = (!astb_cpu_n && !sel0_n) || !astb_ctl_n;

    // R1: strobe on an unselected part issues nothing
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (strobe_seen && !sel_ok) |-> !cmd_valid);

    // R2 / R3: honoured processor strobe always reads
    a_r3_cpu_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!astb_cpu_n && !sel0_n) |-> !cmd_write);

    // R4: controller start uses the presented address
    a_r4_ctl_addr: assert property (@(posedge clk) disable iff (rst)
        (astb_cpu_n && !astb_ctl_n && sel_ok) |-> (cmd_valid && cmd_addr == addr_in));

    // R5: whole-word write carries a full mask
    a_r5_full_mask: assert property (@(posedge clk) disable iff (rst)
        (!wr_all_n && cmd_write) |-> (cmd_mask == '1));

    // R8: hold keeps the previous command address
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!strobe_seen && step_n && cmd_valid && $past(cmd_valid))
        |-> (cmd_addr == $past(cmd_addr)));

    // R12: read result valid one clock later
    a_r12_read_latency: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write) |=> rvalid);
endmodule

bind burst_sram_ctrl sbc_checker #(.AW(AW), .NBYTES(NBYTES)) chk_i (
    .clk(clk), .rst(rst), .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .addr_in(addr_in), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_mask(cmd_mask),
    .rvalid(rvalid)
);

// File: tb/burst_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb_top;
    localparam int AW = 10;
    localparam int NB = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst;
    logic p_n, c_n, e0_n, e1, e2_n, adv_n, gw_n, bwe_n, lin;
    logic [NB-1:0] ln_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic cmd_valid, cmd_write, rvalid;
    logic [AW-1:0] cmd_addr;
    logic [NB-1:0] cmd_mask;
    logic [DW-1:0] rdata;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] shadow [1024];

    always #2 clk = ~clk;

    burst_sram_ctrl #(.AW(AW), .NBYTES(NB), .BYTE_W(8)) dut_i (
        .clk(clk), .rst(rst), .astb_cpu_n(p_n), .astb_ctl_n(c_n),
        .sel0_n(e0_n), .sel1(e1), .sel2_n(e2_n), .step_n(adv_n),
        .wr_all_n(gw_n), .wr_byte_n(bwe_n), .lane_n(ln_n), .lin_order(lin),
        .addr_in(addr), .wdata(wd), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic c, input logic s0, input logic s1,
                         input logic s2, input logic a, input logic g, input logic b,
                         input logic [NB-1:0] l, input logic [AW-1:0] ad,
                         input logic [DW-1:0] d);
        p_n = p; c_n = c; e0_n = s0; e1 = s1; e2_n = s2; adv_n = a;
        gw_n = g; bwe_n = b; ln_n = l; addr = ad; wd = d;
    endtask

    // checks this cycle's command, then moves to the next falling edge
    task automatic expect_cmd(input string req, input logic v, input logic w,
                              input logic [AW-1:0] a, input logic [NB-1:0] m);
        #1;
        check({req, " valid"}, cmd_valid == v, 64'(cmd_valid), 64'(v));
        if (v) begin
            check({req, " write"}, cmd_write == w, 64'(cmd_write), 64'(w));
            check({req, " addr"}, cmd_addr == a, 64'(cmd_addr), 64'(a));
            check({req, " mask"}, cmd_mask == m, 64'(cmd_mask), 64'(m));
            if (w) begin
                for (int b = 0; b < NB; b++)
                    if (m[b]) shadow[a][b*8 +: 8] = wd[b*8 +: 8];
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [AW-1:0] a);
        check({req, " rvalid"}, rvalid == 1'b1, 64'(rvalid), 64'd1);
        check({req, " rdata"}, rdata == shadow[a], 64'(rdata), 64'(shadow[a]));
    endtask

    task automatic idle();
        drive(1, 1, 1, 0, 1, 1, 1, 1, '1, '0, '0);
    endtask

    function automatic logic [1:0] order_lo(input logic mode, input int s, input int k);
        return mode ? 2'((s + k) % 4) : 2'(s ^ k);
    endfunction

    initial begin
        idle();
        lin = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 reset cmd_valid", cmd_valid == 0, 64'(cmd_valid), 0);
        check("R13 reset rvalid", rvalid == 0, 64'(rvalid), 0);
        rst = 1'b0;

        // R11: continue with writes right after reset does nothing
        drive(1, 1, 0, 1, 0, 0, 0, 0, 4'h0, 10'd3, 32'hDEADBEEF);
        expect_cmd("R11 after reset", 0, 0, '0, '0);
        check("R13 rvalid low", rvalid == 0, 64'(rvalid), 0);

        // R4/R5: controller whole-word writes, advance low ignored
        for (int a = 0; a < 40; a++) begin
            drive(1, 0, 0, 1, 0, 0, 0, 1, 4'hF, AW'(a), 32'hA5000000 ^ (a * 32'h01010101));
            expect_cmd("R4 R5 ctl write", 1, 1, AW'(a), 4'hF);
        end

        // R2 R3 R8 R9 R10 R12: both orders, all start values
        for (int mode = 0; mode < 2; mode++) begin
            lin = mode[0];
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] last;
                last = AW'(8 + s);
                drive(0, 0, 0, 1, 0, 0, 0, 0, 4'h0, last, 32'h12345678);
                expect_cmd("R2 R3 cpu start read", 1, 0, last, 4'h0);
                for (int k = 1; k < 4; k++) begin
                    expect_rd("R12 burst read", last);
                    last = AW'(8) + AW'(order_lo(mode[0], s, k));
                    drive(1, 1, 0, 1, 0, 0, 1, 1, 4'hF, 10'h3FF, '0);
                    expect_cmd(mode ? "R9 linear step" : "R10 xor step", 1, 0, last, 4'h0);
                end
                expect_rd("R12 burst read", last);
                drive(1, 1, 1, 0, 1, 1, 1, 1, 4'hF, '0, '0);
                expect_cmd("R8 hold", 1, 0, last, 4'h0);
                expect_rd("R8 hold read", last);
                // wrap back to start on a further advance
                drive(1, 1, 0, 1, 0, 0, 1, 1, 4'hF, '0, '0);
                expect_cmd("R9 R10 wrap", 1, 0, AW'(8 + s), 4'h0);
                expect_rd("R12 wrap read", AW'(8 + s));
            end
        end

        // R3 R6 R7: processor start then masked write on the next clock
        lin = 1'b1;
        drive(0, 1, 0, 1, 0, 1, 0, 0, 4'h0, 10'd20, 32'hFFFFFFFF);
        expect_cmd("R3 cpu start ignores write", 1, 0, 10'd20, 4'h0);
        drive(1, 1, 0, 1, 0, 1, 1, 0, 4'b1010, 10'd99, 32'h11223344);
        expect_cmd("R3 R6 follow-up write", 1, 1, 10'd20, 4'b0101);
        drive(1, 0, 0, 1, 0, 1, 1, 1, 4'h0, 10'd20, '0);
        expect_cmd("R7 readback", 1, 0, 10'd20, 4'h0);
        expect_rd("R7 masked bytes kept", 10'd20);

        // R6 R7: every byte-select pattern
        for (int m = 0; m < 16; m++) begin
            drive(1, 0, 0, 1, 0, 1, 1, 0, ~4'(m), 10'd30, 32'h10203040 + m * 32'h01010101);
            expect_cmd("R6 byte write", 1, m != 0, 10'd30, (m != 0) ? 4'(m) : 4'h0);
            drive(1, 0, 0, 1, 0, 1, 1, 1, 4'h0, 10'd30, '0);
            expect_cmd("R6 bwe high reads", 1, 0, 10'd30, 4'h0);
            expect_rd("R7 merged word", 10'd30);
        end

        // R1 R11: each chip enable alone deselects and ends the burst
        for (int e = 0; e < 3; e++) begin
            drive(1, 0, 0, 1, 0, 1, 1, 1, 4'hF, 10'd5, '0);
            expect_cmd("R1 start", 1, 0, 10'd5, 4'h0);
            drive(1, 0, e == 0, e != 1, e == 2, 1, 0, 1, 4'hF, 10'd6, 32'h0);
            expect_cmd("R1 deselect", 0, 0, '0, '0);
            drive(1, 1, 0, 1, 0, 0, 0, 1, 4'hF, '0, 32'h0);
            expect_cmd("R11 after deselect", 0, 0, '0, '0);
        end

        // R2: processor strobe ignored when sel0_n high; controller strobe deselects
        drive(0, 0, 1, 1, 0, 1, 1, 1, 4'hF, 10'd7, '0);
        expect_cmd("R2 cpu strobe gated", 0, 0, '0, '0);

        // R2: processor strobe ignored with sel0_n high while a burst runs -> hold
        drive(1, 0, 0, 1, 0, 1, 1, 1, 4'hF, 10'd12, '0);
        expect_cmd("R2 start", 1, 0, 10'd12, 4'h0);
        drive(0, 1, 1, 1, 0, 1, 1, 1, 4'hF, 10'd33, '0);
        expect_cmd("R2 gated strobe holds burst", 1, 0, 10'd12, 4'h0);
        expect_rd("R2 hold read", 10'd12);

        idle();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule